// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block is the digital timing core on the converter side of a successive-approximation ADC. An active-low conversion-start strobe is sampled on the rising edge of the conversion clock. When the strobe falls, the block moves the track/hold into hold and raises busy. It then counts conversion-clock edges. The track/hold goes back to track on the 13th rising edge after the start edge. The conversion ends on the 14th falling edge.

At that last edge the block checks the strobe. If the strobe is high, busy drops and the supplied 12-bit sample word is latched as the new result. If the strobe is still low, the conversion is aborted: the result register is kept, busy drops and a one-period abort flag is raised. The result is placed on a tri-stated bus only while chip-select and read are both low. After reset the track/hold is treated as undefined until the first low-to-high transition of the strobe.

Top module: `sar_conv_seq`

## Requirements
- R1: With the block armed and idle and the track/hold in track, a rising clock edge that samples the strobe low, after the previous rising edge sampled it high, starts a conversion. After that edge busy is 1 and track is 0.
- R2: Busy stays 1 from the start edge up to the 14th falling clock edge after the start edge.
- R3: Track returns to 1 on the 13th rising clock edge after the start edge. Track is still 0 after the 12th.
- R4: At the 14th falling edge, if the strobe is high, busy returns to 0 and sample_in is captured as the new result.
- R5: At the 14th falling edge, if the strobe is low, the conversion is aborted. Busy returns to 0, abort is 1 for exactly one clock period, and the result register keeps its earlier value.
- R6: After reset, busy, track, abort and data_oe are 0 and the result is 0. Strobe lows before the first low-to-high strobe transition start nothing. That first transition sets track to 1.
- R7: data_oe is 1, and dbus carries the result, only when cs_n and rd_n are both 0. Otherwise dbus is high-impedance.
- R8: The earlier result stays readable, during a conversion as well, until the next conversion completes.
- R9: Strobe transitions during a conversion neither restart it nor start another one after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnv_n | input | 1 | Conversion-start strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read, active low |
| sample_in | input | 12 | Sample word to be captured at completion |
| busy | output | 1 | Conversion in progress |
| track | output | 1 | 1 = track, 0 = hold |
| dbus | output | 12 | Tri-stated result bus |
| data_oe | output | 1 | Result bus is driven |
| abort | output | 1 | One-period pulse on an aborted conversion |
| abort | | | (see above) |

## Verification
The assertions check the following on every rising edge:
- a qualified strobe fall always leads to busy with the track/hold in hold;
- busy never falls while the track/hold is in hold;
- abort lasts one sample and never coincides with busy;
- the bus value is stable while the block is idle and being read.

Only the bench scenarios can show the exact edge counts, because the count windows are too long to write as properties. These scenarios cover the 13th-rise return to track and the 14th-fall completion. They also cover the abort boundary, where the strobe rises just before or just after that falling edge, and the choice between a captured and a kept result. Finally they cover the ignored strobe activity before arming and during a conversion.

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int W          = 12,
  parameter int TRACK_RISE = 13,
  parameter int END_FALL   = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnv_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic [W-1:0] sample_in,
  output logic         busy,
  output logic         track,
  output logic [W-1:0] dbus,
  output logic         data_oe,
  output logic         abort
);
  localparam int CW = $clog2(END_FALL + 1);

  logic          cnv_q, armed, hold, go_t, end_t;
  logic [CW-1:0] rise_n, fall_n;
  logic [W-1:0]  dout;
  logic          start;

  assign busy    = go_t ^ end_t;
  assign track   = armed & ~hold;
  assign start   = armed & ~busy & ~hold & cnv_q & ~cnv_n;
  assign data_oe = ~cs_n & ~rd_n;
  assign dbus    = data_oe ? dout : 'z;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q  <= 1'b1;
      armed  <= 1'b0;
      hold   <= 1'b0;
      go_t   <= 1'b0;
      rise_n <= '0;
    end else begin
      cnv_q <= cnv_n;
      if (!cnv_q && cnv_n)
        armed <= 1'b1;
      if (start) begin
        go_t   <= ~go_t;
        hold   <= 1'b1;
        rise_n <= '0;
      end else if (busy && hold) begin
        rise_n <= rise_n + CW'(1);
        if (rise_n == CW'(TRACK_RISE - 1))
          hold <= 1'b0;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_t  <= 1'b0;
      fall_n <= '0;
      abort  <= 1'b0;
      dout   <= '0;
    end else begin
      abort <= 1'b0;
      if (busy) begin
        if (fall_n == CW'(END_FALL - 1)) begin
          fall_n <= '0;
          end_t  <= ~end_t;
          if (!cnv_n)
            abort <= 1'b1;
          else
            dout <= sample_in;
        end else begin
          fall_n <= fall_n + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnv_n,
  input logic         busy,
  input logic         track,
  input logic         abort,
  input logic         data_oe,
  input logic [W-1:0] dbus
);
  // R1
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (track && !busy && $past(cnv_n) && !cnv_n) |=> (busy && !track));

  // R3
  track_before_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> track);

  // R5
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !busy);

  // R5
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  // R8
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && data_oe && $past(data_oe)) |-> $stable(dbus));

  // R9
  idle_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $past(track)) |-> track);
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .busy(busy), .track(track),
  .abort(abort), .data_oe(data_oe), .dbus(dbus)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [11:0] sample_in = '0;
  logic        busy, track, data_oe, abort;
  wire  [11:0] dbus;

  int n_cmp = 0;
  int n_bad = 0;
  logic [11:0] last = '0;
  bit finished = 0;

  sar_conv_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .cs_n(cs_n), .rd_n(rd_n),
    .sample_in(sample_in), .busy(busy), .track(track), .dbus(dbus),
    .data_oe(data_oe), .abort(abort)
  );

  always #2 clk = ~clk;

  function automatic bit exp_abort(int low_len);
    return low_len >= 15;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic read_result();
    cs_n = 1'b0; rd_n = 1'b1; #0.5;
    chk("R7 oe rd high", data_oe, 0);
    rd_n = 1'b0; #0.5;
    chk("R7 oe both low", data_oe, 1);
    chk("R8 result", dbus, last);
    cs_n = 1'b1; #0.5;
    chk("R7 oe cs high", data_oe, 0);
    rd_n = 1'b1;
  endtask

  task automatic conv(int low_len, bit glitch, bit rd_mid, logic [11:0] smp);
    sample_in = smp;
    @(posedge clk); #1 cnv_n = 1'b0;
    for (int j = 1; j <= 17; j++) begin
      @(posedge clk); #1;
      if (j == 1)  begin chk("R1 busy", busy, 1); chk("R1 hold", track, 0); end
      if (j == 6 && rd_mid) begin cs_n = 1'b0; rd_n = 1'b0; end
      if (j == 7 && rd_mid) begin
        chk("R8 old result mid", dbus, last); chk("R7 oe mid", data_oe, 1);
        cs_n = 1'b1; rd_n = 1'b1;
      end
      if (j == 13) begin chk("R3 hold at 12", track, 0); chk("R2 busy", busy, 1); end
      if (j == 14) begin chk("R3 track at 13", track, 1); chk("R2 busy end", busy, 1); end
      if (j == 15) begin
        chk("R4 busy low", busy, 0);
        chk("R5 abort", abort, exp_abort(low_len));
      end
      if (j == 16) begin chk("R5 abort pulse", abort, 0); chk("R9 no restart", busy, 0); end
      if (j == 17) chk("R9 idle", busy, 0);
      if (j == low_len) cnv_n = 1'b1;
      if (glitch && j == 5)  cnv_n = 1'b0;
      if (glitch && j == 11) cnv_n = 1'b1;
    end
    if (!exp_abort(low_len)) last = smp;
    read_result();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R6 busy", busy, 0); chk("R6 track", track, 0);
    chk("R6 abort", abort, 0); chk("R6 oe", data_oe, 0);
    read_result();
    cnv_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk("R6 no start", busy, 0); chk("R6 no track", track, 0);
    end
    cnv_n = 1'b1;
    @(posedge clk); #1;
    chk("R6 armed track", track, 1);
    chk("R6 idle", busy, 0);

    conv(1, 0, 1, 12'h5A3);
    conv(14, 0, 0, 12'hFFF);
    conv(15, 0, 1, 12'h123);
    conv(16, 0, 0, 12'h456);
    conv(3, 1, 1, 12'h800);
    conv(13, 0, 0, 12'h001);
    for (int n = 0; n < 40; n++) begin
      int l;
      bit g;
      l = 1 + int'($urandom % 16);
      g = (l < 5) && $urandom[0];
      conv(l, g, $urandom[1], 12'($urandom));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule